// File: doc/BRIEF.md
# Register Busy Scoreboard Checker

This block sits beside a sixteen-entry register file and tracks, for each register, how many cycles remain before the most recent result written to it may legally be read. Each register has its own small down-counter. A write request carries a register index and a latency, and that latency is loaded into the addressed register's counter. On every clock cycle, each counter that is not zero steps down by one.

The block watches two independent operand read ports. When a read is presented on a port and the addressed register's counter is still nonzero, the port raises its own hazard pulse for one cycle. The block only reports hazards. It does not stall the pipeline, forward data or hold any register data. It is meant as a checker in a pipelined datapath or an instruction-level model, where a read of a register that is not yet ready is flagged as an error.

Top module: `busy_scoreboard`

## Requirements
- R1: While `rst` is high at a clock edge, every counter clears to zero. After that edge both `hazard` bits are 0, and they stay 0 until a later write makes a register busy.
- R2: A write (`wr_en`=1) at a clock edge loads the counter of register `wr_idx` with `wr_lat`, a 3-bit latency from 0 to 7.
- R3: At every clock edge, a counter that is not being written and is nonzero decreases by one. A counter that is zero and not being written stays at zero. So after a write with latency L, exactly the next L reads of that register are flagged.
- R4: If a register is written in the same cycle in which its counter would decrement, the write wins and the counter takes the new latency. This applies to a rewrite of a busy register with a longer or a shorter latency.
- R5: A latency of 0 marks the register as ready at once. A read in the following cycle raises no hazard, and this also holds when a busy register is rewritten with latency 0.
- R6: Port p (bit p of `rd_en`, index field `rd_idx[4p+3:4p]`) is checked against the counter value held before the edge. If the port is enabled and that counter is nonzero, `hazard[p]` is 1 for the single cycle that follows the edge. Otherwise it is 0.
- R7: A port whose `rd_en` bit is 0 raises no hazard, whatever register its index selects.
- R8: The two ports are checked independently. They may address the same register or different registers in the same cycle, and each reports its own result.
- R9: A read presented in the same cycle as a write to the same register is checked against the count held before that write, not against the new latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request valid |
| wr_idx | input | 4 | Register index of the write |
| wr_lat | input | 3 | Cycles until the written result may be read |
| rd_en | input | 2 | Read-check valid, one bit per port |
| rd_idx | input | 8 | Read register indices, port 0 in bits 3:0, port 1 in bits 7:4 |
| hazard | output | 2 | Registered hazard pulse, one bit per port |

## Verification
The embedded assertions check on every cycle that each counter reloads on a write, steps down by one when idle and busy, and stays at zero when idle. They also check that a disabled port never flags, that a port reading a busy counter always flags, that two ports aimed at one register agree, and that reset clears both outputs. Some behaviours only the bench scenarios can show, because they depend on how events are ordered in time: the exact count of flagged reads after a write of each latency, the reload of a busy register with a shorter or longer latency, the zero-latency rewrite, and the read that arrives in the same cycle as its write. For these the bench compares each cycle against a model built from the requirements.

// File: rtl/scb_pkg.sv
package scb_pkg;

    localparam int SCB_REGS  = 16;
    localparam int SCB_LAT_W = 3;
    localparam int SCB_PORTS = 2;

    typedef enum logic [1:0] {
        CNT_IDLE = 2'd0,
        CNT_LOAD = 2'd1,
        CNT_DEC  = 2'd2
    } cnt_act_e;

    function automatic cnt_act_e pick_action(input logic load, input logic nonzero);
        if (load)         return CNT_LOAD;
        else if (nonzero) return CNT_DEC;
        else              return CNT_IDLE;
    endfunction

endpackage

// File: rtl/scb_counter.sv
module scb_counter
    import scb_pkg::*;
#(
    parameter int LAT_W = SCB_LAT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LAT_W-1:0] lat,
    output logic [LAT_W-1:0] cnt
);

    cnt_act_e act;

    always_comb act = pick_action(load, cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            case (act)
                CNT_LOAD: cnt <= lat;
                CNT_DEC:  cnt <= cnt - 1'b1;
                default:  cnt <= cnt;
            endcase
        end
    end

    // R2 / R4: a write reloads the counter, even while it is busy
    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == $past(lat));

    // R3: an idle, busy counter steps down by one
    assert_dec_R3: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

    // R3: an idle counter at zero stays at zero
    assert_hold_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt == '0) |=> cnt == '0);

endmodule

// File: rtl/scb_read_check.sv
module scb_read_check
    import scb_pkg::*;
#(
    parameter int NUM_REGS = SCB_REGS,
    parameter int LAT_W    = SCB_LAT_W,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           rd_en,
    input  logic [IDX_W-1:0]               rd_idx,
    input  logic [NUM_REGS-1:0][LAT_W-1:0] cnt_all,
    output logic                           hazard
);

    logic [LAT_W-1:0] sel_cnt;
    logic             busy;

    always_comb begin
        sel_cnt = cnt_all[rd_idx];
        busy    = sel_cnt != '0;
    end

    always_ff @(posedge clk) begin
        if (rst) hazard <= 1'b0;
        else     hazard <= rd_en & busy;
    end

    // R7: a disabled port never flags
    assert_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !hazard);

    // R6: an enabled read of a busy register flags in the next cycle
    assert_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && cnt_all[rd_idx] != '0) |=> hazard);

endmodule

// File: rtl/busy_scoreboard.sv
module busy_scoreboard
    import scb_pkg::*;
#(
    parameter int NUM_REGS  = SCB_REGS,
    parameter int LAT_W     = SCB_LAT_W,
    parameter int NUM_PORTS = SCB_PORTS,
    localparam int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [LAT_W-1:0]           wr_lat,
    input  logic [NUM_PORTS-1:0]       rd_en,
    input  logic [NUM_PORTS*IDX_W-1:0] rd_idx,
    output logic [NUM_PORTS-1:0]       hazard
);

    logic [NUM_REGS-1:0][LAT_W-1:0] cnt_all;
    logic [NUM_REGS-1:0]            load_vec;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        assign load_vec[r] = wr_en && (wr_idx == IDX_W'(r));

        scb_counter #(.LAT_W(LAT_W)) u_cnt (
            .clk  (clk),
            .rst  (rst),
            .load (load_vec[r]),
            .lat  (wr_lat),
            .cnt  (cnt_all[r])
        );
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        scb_read_check #(.NUM_REGS(NUM_REGS), .LAT_W(LAT_W)) u_chk (
            .clk     (clk),
            .rst     (rst),
            .rd_en   (rd_en[p]),
            .rd_idx  (rd_idx[p*IDX_W +: IDX_W]),
            .cnt_all (cnt_all),
            .hazard  (hazard[p])
        );
    end

    // R1: reset leaves both hazard outputs low
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> hazard == '0);

    // R2: at most one counter takes a write per cycle
    assert_one_load_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load_vec));

    // R8: two enabled ports on the same register report the same result
    assert_ports_agree_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en[0] && rd_en[NUM_PORTS-1] &&
         rd_idx[IDX_W-1:0] == rd_idx[(NUM_PORTS-1)*IDX_W +: IDX_W])
        |=> hazard[0] == hazard[NUM_PORTS-1]);

endmodule

// File: tb/sim_busy_scoreboard.sv
module sim_busy_scoreboard;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [3:0] wr_idx;
    logic [2:0] wr_lat;
    logic [1:0] rd_en;
    logic [7:0] rd_idx;
    logic [1:0] hazard;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int model [16];

    always #2.5 clk = ~clk;

    busy_scoreboard u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_lat(wr_lat),
        .rd_en(rd_en), .rd_idx(rd_idx), .hazard(hazard)
    );

    task automatic report_done();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual cycles=%0d expected <= 20000", cycles);
            report_done();
        end
    end

    task automatic expect_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // One cycle: drive at the falling edge, expected values from the model
    // (pre-edge counts), then update the model and check after the edge.
    task automatic step(input string tag, input bit we, input int wi, input int wl,
                        input bit e0, input int i0, input bit e1, input int i1);
        logic x0, x1;
        wr_en  = we;
        wr_idx = 4'(wi);
        wr_lat = 3'(wl);
        rd_en  = {e1, e0};
        rd_idx = {4'(i1), 4'(i0)};
        x0 = e0 && model[i0] != 0;
        x1 = e1 && model[i1] != 0;
        for (int r = 0; r < 16; r++) begin
            if (we && wi == r)    model[r] = wl;
            else if (model[r] > 0) model[r] = model[r] - 1;
        end
        @(negedge clk);
        expect_bit({tag, " port0"}, hazard[0], x0);
        expect_bit({tag, " port1"}, hazard[1], x1);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step("idle", 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1; wr_en = 0; wr_idx = 0; wr_lat = 0; rd_en = 0; rd_idx = 0;
        for (int r = 0; r < 16; r++) model[r] = 0;
        @(negedge clk); @(negedge clk);
        expect_bit("R1 reset port0", hazard[0], 1'b0);
        expect_bit("R1 reset port1", hazard[1], 1'b0);
        rst = 1'b0;
        // all registers read as ready right after reset
        for (int r = 0; r < 16; r++) step("R1 ready after reset", 0, 0, 0, 1, r, 1, 15 - r);
    endtask

    task automatic t_load_count();
        // R2/R3: latency 5 gives exactly five flagged reads; R9 same-cycle read sees old count 0
        step("R9 read with write", 1, 3, 5, 1, 3, 0, 0);
        for (int k = 0; k < 7; k++) step("R2 R3 countdown", 0, 0, 0, 1, 3, 0, 0);
        // maximum latency 7
        step("R2 load max", 1, 9, 7, 0, 0, 0, 0);
        for (int k = 0; k < 9; k++) step("R3 max countdown", 0, 0, 0, 0, 0, 1, 9);
    endtask

    task automatic t_priority();
        // R4: rewrite while busy, longer then shorter latency
        step("R4 first write", 1, 7, 3, 0, 0, 0, 0);
        step("R4 busy read", 0, 0, 0, 1, 7, 0, 0);
        step("R4 reload longer", 1, 7, 6, 1, 7, 0, 0);
        for (int k = 0; k < 3; k++) step("R4 after reload", 0, 0, 0, 1, 7, 0, 0);
        step("R4 reload shorter", 1, 7, 1, 1, 7, 0, 0);
        for (int k = 0; k < 3; k++) step("R4 short tail", 0, 0, 0, 1, 7, 0, 0);
        // R9: a busy register rewritten with a read in the same cycle sees the old count
        step("R9 setup", 1, 2, 4, 0, 0, 0, 0);
        step("R9 write and read", 1, 2, 1, 1, 2, 1, 2);
        step("R9 follow", 0, 0, 0, 1, 2, 0, 0);
    endtask

    task automatic t_zero_latency();
        // R5: latency 0 on an idle register, then on a busy one
        step("R5 zero write", 1, 4, 0, 0, 0, 0, 0);
        step("R5 zero read", 0, 0, 0, 1, 4, 1, 4);
        step("R5 make busy", 1, 4, 6, 0, 0, 0, 0);
        step("R5 busy check", 0, 0, 0, 1, 4, 0, 0);
        step("R5 zero rewrite", 1, 4, 0, 0, 0, 0, 0);
        step("R5 ready again", 0, 0, 0, 1, 4, 1, 4);
    endtask

    task automatic t_disabled();
        // R7: busy register addressed with read-valid low
        step("R7 make busy", 1, 11, 7, 0, 0, 0, 0);
        for (int k = 0; k < 3; k++) step("R7 disabled read", 0, 0, 0, 0, 11, 0, 11);
        step("R7 enabled read", 0, 0, 0, 1, 11, 0, 11);
        idle(6);
    endtask

    task automatic t_two_ports();
        // R8: several registers counting at once, ports on same and different registers
        step("R8 w a", 1, 1, 2, 0, 0, 0, 0);
        step("R8 w b", 1, 14, 5, 1, 1, 1, 14);
        step("R8 w c", 1, 6, 3, 1, 14, 1, 1);
        for (int k = 0; k < 6; k++) step("R8 mixed", 0, 0, 0, 1, 14, 1, 6);
        step("R8 w d", 1, 5, 4, 0, 0, 0, 0);
        for (int k = 0; k < 5; k++) step("R8 same reg", 0, 0, 0, 1, 5, 1, 5);
        step("R8 w e", 1, 0, 3, 0, 0, 0, 0);
        for (int k = 0; k < 4; k++) step("R8 split", 0, 0, 0, 1, 0, 1, 13);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_load_count();
        t_priority();
        t_zero_latency();
        t_disabled();
        t_two_ports();
        // R1: reset mid-run clears busy counters
        step("R1 pre-reset busy", 1, 8, 7, 0, 0, 0, 0);
        rst = 1'b1;
        @(negedge clk);
        for (int r = 0; r < 16; r++) model[r] = 0;
        rst = 1'b0;
        expect_bit("R1 mid reset port0", hazard[0], 1'b0);
        step("R1 cleared", 0, 0, 0, 1, 8, 1, 8);
        report_done();
    end

endmodule